// File: doc/BRIEF.md
# Four-Mode Timer/Event Counter

This block holds two timer/event counters, each made of a low count byte and a high count byte. Each counter picks one of four count structures: a 13-bit count (five prescaler bits in the low byte feeding the high byte), a full 16-bit count, an 8-bit low-byte count that reloads from the high byte when it wraps, or a split structure in which the first counter becomes two separate 8-bit counters. Each counter advances either once per machine-cycle tick or once per falling edge seen on its external count pin.

A host programs the block through a small byte-wide register port: a mode byte, a control byte holding the run bits and the overflow flags, and the four count bytes. A counter only advances while its run bit is set and, when its gate bit is set, while its gate pin is high. Every wrap-around sets an overflow flag, which appears on an output pin until software clears it or the interrupt logic acknowledges it.

Top module: `dual_timer_ctr`

## Requirements
- R1: After reset every register (mode, control, all count bytes) reads 0 and both overflow outputs are 0.
- R2: With the tick source selected (source bit 0), a running counter advances by one on each cycle where tick_i is 1 and holds otherwise.
- R3: With the pin source selected (source bit 1), the pin is sampled on each tick and the counter advances once when a tick sees the pin low after the previous tick saw it high; pin changes between ticks have no effect.
- R4: A counter with its run bit clear does not advance; with its gate bit set it advances only while its gate pin is 1.
- R5: Mode 0: low-byte bits 4:0 form a prescaler; when it is 31 an advance clears it and increments the high byte, low-byte bits 7:5 are left unchanged, and the high byte wrapping from 0xFF sets the flag.
- R6: Mode 1: the high and low bytes form one 16-bit count; an advance from 0xFFFF gives 0x0000 and sets the flag.
- R7: Mode 2: the low byte counts; an advance from 0xFF loads the low byte with the high byte, sets the flag, and leaves the high byte unchanged.
- R8: Mode 3 on counter 0: its low byte counts under counter 0's source, run and gate and sets flag 0; its high byte advances on every tick while run bit 1 is set (ignoring run bit 0) and sets flag 1; counter 1 keeps counting but its overflow does not set flag 1.
- R9: Mode 3 on counter 1 holds both of its count bytes.
- R10: A flag is set on its counter's overflow, cleared by a pulse on its ack_i bit or by a control write with that flag bit 0, and an overflow in the same cycle as a clear leaves the flag set; ovf_o mirrors the flags.
- R11: Register map: address 0 mode byte (bits 1:0 mode, bit 2 source, bit 3 gate for counter 0; bits 5:4, 6, 7 likewise for counter 1); address 1 control (bit 0 run 0, bit 1 run 1, bit 2 flag 0, bit 3 flag 1, bits 7:4 read 0); addresses 2 and 3 counter 0 low and high; 4 and 5 counter 1 low and high; a write lands on the next clock and reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Machine-cycle tick, one clock wide |
| ext_cnt_i | input | 2 | External count pins, one per counter |
| gate_pin_i | input | 2 | Gate pins, one per counter |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| ack_i | input | 2 | Overflow acknowledge, one per flag |
| ovf_o | output | 2 | Overflow flags |

## Verification
Each count structure is started just below its wrap point, so that one or two ticks show the ordinary step, the carry between bytes and the flag, which separates a prescaler carry from a 16-bit carry from a reload. The pin source is driven with high-low sequences both at ticks and between ticks, telling true edge counting from level counting. The split mode is run with counter 1 also near its wrap and with run bit 0 cleared, so the test can tell which counter owns flag 1 and which run bit drives the high byte. Flag clearing is tried by ack, by register write, and by an ack that coincides with an overflow.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned CNT_W   = 8;
  localparam int unsigned PRESC_W = 5;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned N_TMR   = 2;

  localparam logic [ADDR_W-1:0] ADDR_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd1;
  localparam int unsigned       ADDR_CNT_BASE = 2;

  typedef enum logic [1:0] {
    MODE_PRESC  = 2'd0,
    MODE_WIDE   = 2'd1,
    MODE_RELOAD = 2'd2,
    MODE_SPLIT  = 2'd3
  } tmr_mode_e;
endpackage

// File: rtl/tmr_edge.sv
module tmr_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic pin_i,
  output logic fall_o
);
  logic smp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     smp_q <= 1'b0;
    else if (tick_i) smp_q <= pin_i;
  end

  // high at previous tick, low at this one
  assign fall_o = tick_i & smp_q & ~pin_i;
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned PRESC_W = 5,
  parameter bit          SPLIT   = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  tmr_mode_e        mode_i,
  input  logic             inc_lo_i,
  input  logic             inc_hi_i,
  input  logic             wr_lo_i,
  input  logic             wr_hi_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] lo_o,
  output logic [CNT_W-1:0] hi_o,
  output logic             ovf_a_o,
  output logic             ovf_b_o
);
  logic [CNT_W-1:0]   lo_q, hi_q, lo_d, hi_d;
  logic [PRESC_W-1:0] presc;
  logic               ov_a, ov_b;

  assign presc = lo_q[PRESC_W-1:0];

  always_comb begin
    lo_d = lo_q;
    hi_d = hi_q;
    ov_a = 1'b0;
    ov_b = 1'b0;
    unique case (mode_i)
      MODE_PRESC: if (inc_lo_i) begin
        if (&presc) begin
          lo_d[PRESC_W-1:0] = '0;
          hi_d = hi_q + 1'b1;
          ov_a = &hi_q;
        end else begin
          lo_d[PRESC_W-1:0] = presc + 1'b1;
        end
      end
      MODE_WIDE: if (inc_lo_i) begin
        {hi_d, lo_d} = {hi_q, lo_q} + 1'b1;
        ov_a = &{hi_q, lo_q};
      end
      MODE_RELOAD: if (inc_lo_i) begin
        if (&lo_q) begin
          lo_d = hi_q;
          ov_a = 1'b1;
        end else begin
          lo_d = lo_q + 1'b1;
        end
      end
      MODE_SPLIT: if (SPLIT) begin
        if (inc_lo_i) begin
          lo_d = lo_q + 1'b1;
          ov_a = &lo_q;
        end
        if (inc_hi_i) begin
          hi_d = hi_q + 1'b1;
          ov_b = &hi_q;
        end
      end
      default: ;
    endcase
    if (wr_lo_i) lo_d = wdata_i;
    if (wr_hi_i) hi_d = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign lo_o    = lo_q;
  assign hi_o    = hi_q;
  assign ovf_a_o = ov_a;
  assign ovf_b_o = ov_b;

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_lo_i && !inc_hi_i && !wr_lo_i && !wr_hi_i |=> $stable(lo_q) && $stable(hi_q)); // R4

  AST_WIDE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == MODE_WIDE && inc_lo_i && (&{hi_q, lo_q}) && !wr_lo_i && !wr_hi_i
    |=> lo_q == '0 && hi_q == '0); // R6

  AST_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == MODE_RELOAD && inc_lo_i && (&lo_q) && !wr_lo_i && !wr_hi_i
    |=> lo_q == $past(hi_q) && $stable(hi_q)); // R7

  if (!SPLIT) begin : g_hold_chk
    AST_SPLIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mode_i == MODE_SPLIT && !wr_lo_i && !wr_hi_i |=> $stable(lo_q) && $stable(hi_q)); // R9
  end
endmodule

// File: rtl/dual_timer_ctr.sv
module dual_timer_ctr
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W   = tmr_pkg::CNT_W,
  parameter int unsigned PRESC_W = tmr_pkg::PRESC_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic [N_TMR-1:0]    ext_cnt_i,
  input  logic [N_TMR-1:0]    gate_pin_i,
  input  logic                reg_we_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [CNT_W-1:0]    reg_wdata_i,
  output logic [CNT_W-1:0]    reg_rdata_o,
  input  logic [N_TMR-1:0]    ack_i,
  output logic [N_TMR-1:0]    ovf_o
);
  localparam int unsigned MODE_W = 4 * N_TMR;

  logic [MODE_W-1:0] mode_q;
  logic [N_TMR-1:0]  run_q, flag_q, flag_d, flag_set;
  logic [N_TMR-1:0]  fall, en, inc_lo, inc_hi, ovf_a, ovf_b, sel, gate;
  tmr_mode_e         t_mode [N_TMR];
  logic [CNT_W-1:0]  lo [N_TMR];
  logic [CNT_W-1:0]  hi [N_TMR];
  logic              wr_mode, wr_ctrl;

  assign wr_mode = reg_we_i && reg_addr_i == ADDR_MODE;
  assign wr_ctrl = reg_we_i && reg_addr_i == ADDR_CTRL;

  assign inc_hi[0] = tick_i & run_q[1];
  assign inc_hi[1] = 1'b0;

  for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
    localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(ADDR_CNT_BASE + 2 * i);
    localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(ADDR_CNT_BASE + 2 * i + 1);

    assign t_mode[i] = tmr_mode_e'(mode_q[4*i +: 2]);
    assign sel[i]    = mode_q[4*i + 2];
    assign gate[i]   = mode_q[4*i + 3];

    tmr_edge u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick_i),
      .pin_i  (ext_cnt_i[i]),
      .fall_o (fall[i])
    );

    assign en[i]     = run_q[i] & (~gate[i] | gate_pin_i[i]);
    assign inc_lo[i] = en[i] & (sel[i] ? fall[i] : tick_i);

    tmr_core #(
      .CNT_W   (CNT_W),
      .PRESC_W (PRESC_W),
      .SPLIT   (i == 0)
    ) u_core (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .mode_i   (t_mode[i]),
      .inc_lo_i (inc_lo[i]),
      .inc_hi_i (inc_hi[i]),
      .wr_lo_i  (reg_we_i && reg_addr_i == A_LO),
      .wr_hi_i  (reg_we_i && reg_addr_i == A_HI),
      .wdata_i  (reg_wdata_i),
      .lo_o     (lo[i]),
      .hi_o     (hi[i]),
      .ovf_a_o  (ovf_a[i]),
      .ovf_b_o  (ovf_b[i])
    );

    always_comb begin
      if (flag_set[i])   flag_d[i] = 1'b1;
      else if (wr_ctrl)  flag_d[i] = reg_wdata_i[2 + i];
      else if (ack_i[i]) flag_d[i] = 1'b0;
      else               flag_d[i] = flag_q[i];
    end

    AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flag_set[i] |=> ovf_o[i]); // R10

    AST_FLAG_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ack_i[i] && !flag_set[i] && !wr_ctrl |=> !ovf_o[i]); // R10
  end

  // split mode hands flag 1 to counter 0's high byte
  assign flag_set[0] = ovf_a[0];
  assign flag_set[1] = (t_mode[0] == MODE_SPLIT) ? ovf_b[0] : (ovf_a[1] | ovf_b[1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      run_q  <= '0;
      flag_q <= '0;
    end else begin
      if (wr_mode) mode_q <= reg_wdata_i[MODE_W-1:0];
      if (wr_ctrl) run_q  <= reg_wdata_i[N_TMR-1:0];
      flag_q <= flag_d;
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      3'd0:    reg_rdata_o = CNT_W'(mode_q);
      3'd1:    reg_rdata_o = CNT_W'({flag_q, run_q});
      3'd2:    reg_rdata_o = lo[0];
      3'd3:    reg_rdata_o = hi[0];
      3'd4:    reg_rdata_o = lo[1];
      3'd5:    reg_rdata_o = hi[1];
      default: reg_rdata_o = '0;
    endcase
  end

  assign ovf_o = flag_q;

  AST_SPLIT_HI_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    t_mode[0] == MODE_SPLIT && !run_q[1] && !reg_we_i |=> $stable(hi[0])); // R8
endmodule

// File: tb/sim_dual_timer_ctr.sv
module sim_dual_timer_ctr;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic [1:0] ext_cnt_i = 2'b00;
  logic [1:0] gate_pin_i = 2'b00;
  logic       reg_we_i = 1'b0;
  logic [2:0] reg_addr_i = 3'd0;
  logic [7:0] reg_wdata_i = 8'h00;
  logic [7:0] reg_rdata_o;
  logic [1:0] ack_i = 2'b00;
  logic [1:0] ovf_o;

  int errors = 0;
  int checks = 0;

  always #10 clk_i = ~clk_i;

  dual_timer_ctr u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .ext_cnt_i(ext_cnt_i),
    .gate_pin_i(gate_pin_i), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .ack_i(ack_i), .ovf_o(ovf_o)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
    reg_addr_i = a;
    #1;
    chk(req, reg_rdata_o, exp);
  endtask

  task automatic tick(input logic [1:0] ack = 2'b00);
    @(negedge clk_i);
    tick_i = 1'b1; ack_i = ack;
    @(negedge clk_i);
    tick_i = 1'b0; ack_i = 2'b00;
  endtask

  task automatic t_reset;
    for (int a = 0; a < 6; a++) rd_chk("R1 reg", 3'(a), 8'h00);
    chk("R1 ovf", ovf_o, 0);
  endtask

  task automatic t_wide;
    wr(3'd0, 8'h01); wr(3'd2, 8'hFE); wr(3'd3, 8'hFF); wr(3'd1, 8'h01);
    tick();
    rd_chk("R2 lo step", 3'd2, 8'hFF);
    chk("R6 no flag yet", ovf_o, 0);
    tick();
    rd_chk("R6 lo wrap", 3'd2, 8'h00);
    rd_chk("R6 hi wrap", 3'd3, 8'h00);
    chk("R6 flag", ovf_o, 1);
    @(negedge clk_i); ack_i = 2'b01;
    @(negedge clk_i); ack_i = 2'b00;
    chk("R10 ack clears", ovf_o, 0);
    @(negedge clk_i);
    rd_chk("R2 holds without tick", 3'd2, 8'h00);
  endtask

  task automatic t_gate;
    wr(3'd1, 8'h00); wr(3'd0, 8'h09); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    tick();
    rd_chk("R4 run off", 3'd2, 8'h00);
    wr(3'd1, 8'h01);
    gate_pin_i = 2'b00;
    tick();
    rd_chk("R4 gate low", 3'd2, 8'h00);
    gate_pin_i = 2'b01;
    tick();
    rd_chk("R4 gate high", 3'd2, 8'h01);
    gate_pin_i = 2'b00;
  endtask

  task automatic t_pin;
    wr(3'd0, 8'h05); wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd1, 8'h01);
    ext_cnt_i[0] = 1'b1; tick();
    rd_chk("R3 high no count", 3'd2, 8'h00);
    ext_cnt_i[0] = 1'b0; tick();
    rd_chk("R3 first fall", 3'd2, 8'h01);
    tick();
    rd_chk("R3 low level no count", 3'd2, 8'h01);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i) ext_cnt_i[0] = 1'b1;
      @(negedge clk_i) ext_cnt_i[0] = 1'b0;
    end
    rd_chk("R3 between ticks", 3'd2, 8'h01);
    ext_cnt_i[0] = 1'b1; tick();
    ext_cnt_i[0] = 1'b0; tick();
    rd_chk("R3 second fall", 3'd2, 8'h02);
  endtask

  task automatic t_presc;
    wr(3'd1, 8'h00); wr(3'd0, 8'h00); wr(3'd2, 8'hFE); wr(3'd3, 8'h00); wr(3'd1, 8'h01);
    tick();
    rd_chk("R5 presc step", 3'd2, 8'hFF);
    rd_chk("R5 hi held", 3'd3, 8'h00);
    tick();
    rd_chk("R5 presc carry lo", 3'd2, 8'hE0);
    rd_chk("R5 presc carry hi", 3'd3, 8'h01);
    wr(3'd2, 8'h1F); wr(3'd3, 8'hFF);
    tick();
    rd_chk("R5 wrap hi", 3'd3, 8'h00);
    chk("R5 flag", ovf_o, 1);
    wr(3'd1, 8'h01);
    chk("R10 write clears", ovf_o, 0);
  endtask

  task automatic t_reload;
    wr(3'd0, 8'h02); wr(3'd3, 8'hF0); wr(3'd2, 8'hFE);
    tick();
    rd_chk("R7 step", 3'd2, 8'hFF);
    tick();
    rd_chk("R7 reload lo", 3'd2, 8'hF0);
    rd_chk("R7 hi kept", 3'd3, 8'hF0);
    chk("R7 flag", ovf_o, 1);
    wr(3'd1, 8'h01);
  endtask

  task automatic t_split;
    wr(3'd1, 8'h00); wr(3'd0, 8'h13);
    wr(3'd2, 8'hFF); wr(3'd3, 8'h00); wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
    wr(3'd1, 8'h03);
    tick();
    rd_chk("R8 lo0 wrap", 3'd2, 8'h00);
    rd_chk("R8 hi0 step", 3'd3, 8'h01);
    rd_chk("R8 t1 still counts", 3'd4, 8'h00);
    chk("R8 flags", ovf_o, 1);
    wr(3'd1, 8'h02); wr(3'd2, 8'h05); wr(3'd3, 8'hFF);
    tick();
    rd_chk("R8 lo0 stopped", 3'd2, 8'h05);
    rd_chk("R8 hi0 runs on run1", 3'd3, 8'h00);
    chk("R8 hi0 owns flag1", ovf_o, 2);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_t1_hold;
    wr(3'd0, 8'h30); wr(3'd4, 8'h12); wr(3'd5, 8'h34); wr(3'd1, 8'h02);
    tick(); tick(); tick();
    rd_chk("R9 lo1 held", 3'd4, 8'h12);
    rd_chk("R9 hi1 held", 3'd5, 8'h34);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_set_wins;
    wr(3'd0, 8'h01); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF); wr(3'd1, 8'h01);
    tick(2'b01);
    chk("R10 set beats ack", ovf_o, 1);
    wr(3'd1, 8'h00);
    chk("R10 cleared", ovf_o, 0);
  endtask

  task automatic t_map;
    wr(3'd0, 8'hA5);
    rd_chk("R11 mode byte", 3'd0, 8'hA5);
    wr(3'd1, 8'hFF);
    rd_chk("R11 ctrl byte", 3'd1, 8'h0F);
    chk("R11 flags from ctrl", ovf_o, 3);
    wr(3'd1, 8'h00);
    rd_chk("R11 unused addr", 3'd7, 8'h00);
  endtask

  initial begin
    #100000000;
    errors++;
    $display("FAIL watchdog: got 0x1 expected 0x0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_wide();
    t_gate();
    t_pin();
    t_presc();
    t_reload();
    t_split();
    t_t1_hold();
    t_set_wins();
    t_map();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule